// File: doc/BRIEF.md
# DSP Interrupt Control and Status Register

This block is a single 16-bit control and status word that sits between a DSP subsystem and the host processor. It collects interrupt events from three sources: the DSP itself, an auxiliary-memory DMA engine, and the audio DMA engine. It reduces them to one interrupt line toward the host. Each source owns a status bit, and the enable mask for that source is the bit directly above its status bit. A source is therefore active for the interrupt line when a status bit and its left-hand neighbour are both 1.

Software writes the whole word at once. Status bits are cleared by writing 1 to them. Mask bits, the DSP control bits (reset, assert-interrupt, halt, init, init code) and the four padding bits take the written value as given. A write that sets any padding bit raises a one-cycle error pulse. A write with the reset bit set also sends a one-cycle pulse to the audio DMA engine so that it clears its control word. A busy flag from the auxiliary DMA engine is mirrored into a read-only bit.

Bit layout: 0 reset, 1 assert-interrupt, 2 halt, 3 DSP status, 4 DSP mask, 5 aux-DMA status, 6 aux-DMA mask, 7 audio status, 8 audio mask, 9 DMA busy (read-only), 10 init, 11 init code, 15:12 padding.

Top module: `dsp_irq_csr`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `csr_q` equals 16'h0004 (only the halt bit, bit 2, is set), and `irq_o`, `pad_err_o` and `aud_clr_o` are 0.
- R2: A 1 on `evt_vec` bit 3, 5 or 7 sets the same bit of `csr_q` on the next edge. A 1 on any other `evt_vec` bit changes nothing.
- R3: A write (`wr_en` high) with `wr_data` bit 3, 5 or 7 at 1 clears that status bit. A 0 in that position leaves it unchanged. When a clear and an event meet on the same bit in the same cycle, the bit ends up set.
- R4: A write copies `wr_data` bits 0, 1, 2, 4, 6, 8, 10 and 11 into the same bits of `csr_q`. With `wr_en` low, those bits hold their value.
- R5: `aud_clr_o` is high for exactly the one cycle after a write whose `wr_data` bit 0 is 1, and is low at all other times.
- R6: A write with any of `wr_data` bits 15:12 nonzero drives `pad_err_o` high for the following cycle, and those bits are stored in `csr_q[15:12]`. A write with those bits all zero leaves `pad_err_o` low.
- R7: `irq_o` is registered. At every cycle it equals the OR over the three pairs of (`csr_q` bit 3 AND bit 4), (bit 5 AND bit 6) and (bit 7 AND bit 8), and it changes on the same edge as the register.
- R8: `csr_q` bit 9 shows the value `dma_busy_i` had at the previous edge. A write to bit 9 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 16 | Write data |
| evt_vec | input | 16 | Event pulses aligned to register bit positions |
| dma_busy_i | input | 1 | Busy flag from the auxiliary DMA engine |
| csr_q | output | 16 | Current register value |
| irq_o | output | 1 | Registered interrupt request to the host |
| pad_err_o | output | 1 | One-cycle pulse: write touched padding bits |
| aud_clr_o | output | 1 | One-cycle pulse: clear the audio DMA control word |

## Verification
The assertions assume that `wr_en`, `wr_data`, `evt_vec` and `dma_busy_i` are known and steady around each rising edge. They also assume that an event and a write-one-to-clear on the same status bit resolve with the event winning. The stimulus changes inputs only on falling edges. It deliberately drives events on the non-status positions, and drives a clear and a set into the same status bit in the same cycle. This way every assertion's antecedent is reached while the inputs stay within those assumptions.

// File: rtl/dsp_irq_pkg.sv
// Package: shared layout constants for the DSP interrupt control register.
// Assumes a fixed 16-bit word; source k has status at 3+2k and mask at 4+2k.
package dsp_irq_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_SRC   = 3;
    localparam int BIT_RST   = 0;
    localparam int BIT_AINT  = 1;
    localparam int BIT_HALT  = 2;
    localparam int BIT_BUSY  = 9;
    localparam int BIT_INIT  = 10;
    localparam int BIT_ICODE = 11;
    localparam int PAD_LO    = 12;
    localparam int PAD_W     = REG_W - PAD_LO;
    localparam logic [REG_W-1:0] RESET_VAL = 16'h0004;

    // Status bit position of interrupt source k.
    function automatic int stat_pos(input int k);
        return 3 + 2 * k;
    endfunction

    // Mask bit position of interrupt source k (always one above its status).
    function automatic int mask_pos(input int k);
        return stat_pos(k) + 1;
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
// Module: status flags of the interrupt sources.
// Each flag is set by its event pulse and cleared by a write of 1.
// When both happen in one cycle the event wins, so no event is lost.
// Also exposes the next-state value so the interrupt can be registered in step.
module irq_status_bank
    import dsp_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] set_bits,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] stat_d
);
    for (genvar g = 0; g < N; g++) begin : g_src
        // Next state: clear on a write of 1, then set on an event.
        always_comb begin
            stat_d[g] = stat_q[g];
            if (wr_en && clr_bits[g]) stat_d[g] = 1'b0;
            if (set_bits[g])          stat_d[g] = 1'b1;
        end

        // Flag storage.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q[g] <= 1'b0;
            else        stat_q[g] <= stat_d[g];
        end
    end
endmodule

// File: rtl/ctrl_field_bank.sv
// Module: bits that software writes directly (masks, DSP control bits, padding),
// plus the read-only DMA busy mirror. The reset value has only halt set.
// Assumes that a write carries the whole word.
module ctrl_field_bank
    import dsp_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N-1:0]     wr_mask,
    input  logic [4:0]       wr_ctl,
    input  logic [PAD_W-1:0] wr_pad,
    input  logic             dma_busy_i,
    output logic [N-1:0]     mask_q,
    output logic [N-1:0]     mask_d,
    output logic [4:0]       ctl_q,
    output logic [PAD_W-1:0] pad_q,
    output logic             busy_q
);
    // ctl order: {icode, init, halt, aint, rst}
    localparam logic [4:0] CTL_RST = 5'b00100;

    // Next mask value, needed by the interrupt register in the same cycle.
    always_comb mask_d = wr_en ? wr_mask : mask_q;

    // Mask, control and padding storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ctl_q  <= CTL_RST;
            pad_q  <= '0;
        end else begin
            mask_q <= mask_d;
            if (wr_en) begin
                ctl_q <= wr_ctl;
                pad_q <= wr_pad;
            end
        end
    end

    // Busy mirror; not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= dma_busy_i;
    end
endmodule

// File: rtl/write_side_fx.sv
// Module: one-cycle pulses caused by a write: padding error and audio DMA clear.
// Assumes wr_en lasts one cycle per write.
module write_side_fx
    import dsp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_rst_bit,
    input  logic [PAD_W-1:0] wr_pad,
    output logic             pad_err_o,
    output logic             aud_clr_o
);
    // Register the pulses so they appear in the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_err_o <= 1'b0;
            aud_clr_o <= 1'b0;
        end else begin
            pad_err_o <= wr_en && (|wr_pad);
            aud_clr_o <= wr_en && wr_rst_bit;
        end
    end
endmodule

// File: rtl/irq_reduce.sv
// Module: registered interrupt request, the OR of enabled, active sources.
// Takes next-state status and mask so it changes on the same edge as the register.
module irq_reduce
    import dsp_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_d,
    input  logic [N-1:0] mask_d,
    output logic         irq_o
);
    // Interrupt flop.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(stat_d & mask_d);
    end
endmodule

// File: rtl/dsp_irq_csr.sv
// Module: top of the DSP interrupt control/status register.
// Splits the written word into fields, instantiates the banks, and reassembles the read value.
// Assumes evt_vec is aligned to register bit positions; only status positions are used.
module dsp_irq_csr
    import dsp_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] evt_vec,
    input  logic             dma_busy_i,
    output logic [REG_W-1:0] csr_q,
    output logic             irq_o,
    output logic             pad_err_o,
    output logic             aud_clr_o
);
    logic [NUM_SRC-1:0] clr_bits, set_bits, wr_mask;
    logic [NUM_SRC-1:0] stat_q, stat_d, mask_q, mask_d;
    logic [4:0]         wr_ctl, ctl_q;
    logic [PAD_W-1:0]   wr_pad, pad_q;
    logic               busy_q;
    logic               unused_bits;

    // Pick out the per-source fields.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fields
        assign clr_bits[g] = wr_data[stat_pos(g)];
        assign set_bits[g] = evt_vec[stat_pos(g)];
        assign wr_mask[g]  = wr_data[mask_pos(g)];
    end

    assign wr_ctl = {wr_data[BIT_ICODE], wr_data[BIT_INIT], wr_data[BIT_HALT],
                     wr_data[BIT_AINT], wr_data[BIT_RST]};
    assign wr_pad = wr_data[REG_W-1:PAD_LO];
    // Bits that are not used on purpose: the busy position of a write, and non-status events.
    assign unused_bits = ^{wr_data[BIT_BUSY], evt_vec[2:0], evt_vec[4], evt_vec[6],
                           evt_vec[REG_W-1:8]};

    irq_status_bank #(.N(NUM_SRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .clr_bits(clr_bits), .set_bits(set_bits),
        .stat_q(stat_q), .stat_d(stat_d)
    );

    ctrl_field_bank #(.N(NUM_SRC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_mask(wr_mask), .wr_ctl(wr_ctl), .wr_pad(wr_pad),
        .dma_busy_i(dma_busy_i),
        .mask_q(mask_q), .mask_d(mask_d), .ctl_q(ctl_q), .pad_q(pad_q), .busy_q(busy_q)
    );

    write_side_fx u_fx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_rst_bit(wr_data[BIT_RST]), .wr_pad(wr_pad),
        .pad_err_o(pad_err_o), .aud_clr_o(aud_clr_o)
    );

    irq_reduce #(.N(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .stat_d(stat_d), .mask_d(mask_d), .irq_o(irq_o)
    );

    // Reassemble the read value.
    always_comb begin
        csr_q = '0;
        csr_q[BIT_RST]   = ctl_q[0];
        csr_q[BIT_AINT]  = ctl_q[1];
        csr_q[BIT_HALT]  = ctl_q[2];
        csr_q[BIT_INIT]  = ctl_q[3];
        csr_q[BIT_ICODE] = ctl_q[4];
        csr_q[BIT_BUSY]  = busy_q;
        csr_q[REG_W-1:PAD_LO] = pad_q;
        for (int k = 0; k < NUM_SRC; k++) begin
            csr_q[stat_pos(k)] = stat_q[k];
            csr_q[mask_pos(k)] = mask_q[k];
        end
    end
endmodule

// File: rtl/dsp_irq_csr_checker.sv
// Module: assertion checker for dsp_irq_csr, attached by bind below.
module dsp_irq_csr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] evt_vec,
    input logic        dma_busy_i,
    input logic [15:0] csr_q,
    input logic        irq_o,
    input logic        pad_err_o,
    input logic        aud_clr_o
);
    p_irq_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((csr_q[3] & csr_q[4]) | (csr_q[5] & csr_q[6]) | (csr_q[7] & csr_q[8])));

    p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vec[5] |=> csr_q[5]);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3] && !evt_vec[3]) |=> !csr_q[3]);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !evt_vec[7]) |=> $stable(csr_q[7]));

    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr_q[6] == $past(wr_data[6])));

    p_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[15:12] != 4'd0)) |=> pad_err_o);

    p_clr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0]) |=> aud_clr_o);

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy_i |=> csr_q[9]);
endmodule

bind dsp_irq_csr dsp_irq_csr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .evt_vec(evt_vec),
    .dma_busy_i(dma_busy_i), .csr_q(csr_q), .irq_o(irq_o),
    .pad_err_o(pad_err_o), .aud_clr_o(aud_clr_o)
);

// File: tb/dsp_irq_csr_tb_top.sv
// Bench: behavioural reference model updated on each rising edge and compared on each falling edge.
module dsp_irq_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] evt_vec = '0;
    logic        dma_busy_i = 1'b0;
    logic [15:0] csr_q;
    logic        irq_o, pad_err_o, aud_clr_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_reg = 16'h0004;
    logic        m_irq = 0, m_pad = 0, m_clr = 0;

    localparam logic [15:0] DIRECT = 16'hFD57; // bits 0,1,2,4,6,8,10,11,15:12
    localparam logic [15:0] STAT   = 16'h00A8; // bits 3,5,7

    always #5 clk = ~clk;

    dsp_irq_csr dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .evt_vec(evt_vec),
        .dma_busy_i(dma_busy_i), .csr_q(csr_q), .irq_o(irq_o),
        .pad_err_o(pad_err_o), .aud_clr_o(aud_clr_o)
    );

    // Reference model step
    always @(posedge clk) begin
        logic [15:0] n;
        if (!rst_n) begin
            m_reg = 16'h0004; m_irq = 0; m_pad = 0; m_clr = 0;
        end else begin
            n = m_reg;
            if (wr_en) begin
                n = (n & ~DIRECT) | (wr_data & DIRECT);
                n = n & ~(wr_data & STAT);
            end
            n = n | (evt_vec & STAT);
            n[9] = dma_busy_i;
            m_irq = (n[3] & n[4]) | (n[5] & n[6]) | (n[7] & n[8]);
            m_pad = wr_en && (wr_data[15:12] != 0);
            m_clr = wr_en && wr_data[0];
            m_reg = n;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2/R3 status", csr_q & STAT, m_reg & STAT);
            chk("R4 direct", csr_q & 16'h0D57, m_reg & 16'h0D57);
            chk("R6 padding", {12'd0, csr_q[15:12]}, {12'd0, m_reg[15:12]});
            chk("R8 busy", {15'd0, csr_q[9]}, {15'd0, m_reg[9]});
            chk("R7 irq", {15'd0, irq_o}, {15'd0, m_irq});
            chk("R6 pad_err", {15'd0, pad_err_o}, {15'd0, m_pad});
            chk("R5 aud_clr", {15'd0, aud_clr_o}, {15'd0, m_clr});
        end
    end

    task automatic step(input logic w, input logic [15:0] d, input logic [15:0] e, input logic b);
        wr_en = w; wr_data = d; evt_vec = e; dma_busy_i = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset csr", csr_q, 16'h0004);
        chk("R1 reset flags", {13'd0, irq_o, pad_err_o, aud_clr_o}, 16'd0);
        // R2 ignored events on non-status positions, then each source
        step(0, 0, 16'hFF57, 0);
        step(0, 0, 0, 0);
        chk("R2 ignored events", csr_q, 16'h0004);
        step(0, 0, 16'h0008, 0);
        step(0, 0, 16'h0020, 0);
        step(0, 0, 16'h0080, 0);
        step(0, 0, 0, 0);
        chk("R2 all set", csr_q & STAT, STAT);
        chk("R7 no irq while masked", {15'd0, irq_o}, 16'd0);
        // R4 enable masks, R7 irq rises
        step(1, 16'h0150, 0, 0);
        chk("R7 irq with masks", {15'd0, irq_o}, 16'd1);
        // R3 write 0 keeps status, write 1 clears
        step(1, 16'h0150, 0, 0);
        chk("R3 zero keeps", csr_q & STAT, STAT);
        step(1, 16'h01F8, 0, 0);
        chk("R3 cleared", csr_q & STAT, 16'd0);
        chk("R7 irq low", {15'd0, irq_o}, 16'd0);
        // R3 clear and set together: set wins
        step(1, 16'h0178, 16'h0020, 0);
        chk("R3 set wins", csr_q & STAT, 16'h0020);
        // R5 reset bit pulse, R6 padding, R8 busy and write to bit 9
        step(1, 16'h0201, 0, 1);
        chk("R5 aud_clr pulse", {15'd0, aud_clr_o}, 16'd1);
        chk("R8 busy mirrored", {15'd0, csr_q[9]}, 16'd1);
        step(0, 0, 0, 0);
        chk("R5 single cycle", {15'd0, aud_clr_o}, 16'd0);
        chk("R8 busy cleared", {15'd0, csr_q[9]}, 16'd0);
        step(1, 16'hA000, 0, 0);
        chk("R6 pad error", {15'd0, pad_err_o}, 16'd1);
        chk("R6 pad stored", {12'd0, csr_q[15:12]}, 16'h000A);
        // Pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[31:16], (r[2] ? r[27:12] : 16'd0), r[3]);
        end
        // Synchronous reset again mid-run, R1
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        chk("R1 reset again", csr_q, 16'h0004);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        done = 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule